// File: doc/BRIEF.md
# UART FIFO Trigger-Level Controller

This block is the buffering front end of one UART channel. It holds a transmit byte queue and a receive byte queue, each `DEPTH` entries deep, and a one-byte control register. The register selects whether the queues are in use, sets a separate fill threshold for each direction, and carries two write-one pulse bits that empty either queue.

The transmit request is raised while the transmit queue has drained to its threshold, so the host can refill it. The receive request is raised once the receive queue has filled to its threshold, so the host can drain it. When the queues are switched off, each direction acts as a single-byte holding register. Levels, requests and read data are all registered.

Top module: `uart_fifo_trigctl`

## Requirements
- R1: After synchronous reset, `cfg_rdata` is 0, both levels are 0, `tx_req` is 1, `rx_req` is 0 and both overrun flags are 0.
- R2: A write to the control byte stores bits [7:6] as the transmit threshold code, bits [5:4] as the receive threshold code and bit 0 as the queue enable. The readback places these fields at the same positions. Bit 3 and bits [2:1] always read 0.
- R3: Each accepted push raises the level by one on the next cycle. Bytes leave in push order. The byte popped in one cycle appears on the `*_dout` port on the following cycle.
- R4: With queues enabled, a queue holds `DEPTH` bytes. A push into a full queue is dropped, leaves the level unchanged, and sets the direction's overrun flag for exactly the next cycle.
- R5: A pop from an empty queue leaves the level at 0 and keeps `*_dout` at its previous value.
- R6: With queues enabled, `tx_req` is 1 exactly while `tx_level` is at or below the selected limit: 0 for code 00, 16 for 01, 32 for 10 and 48 for 11 (at `DEPTH`=64). It updates in the same cycle as the level.
- R7: With queues enabled, `rx_req` is 1 exactly while `rx_level` is at or above the selected limit: 1 for code 00, 8 for 01, 16 for 10 and 32 for 11 (at `DEPTH`=64).
- R8: With queues disabled, each queue holds one byte and a second push counts as an overrun. `tx_req` is 1 only at level 0, and `rx_req` is 1 only at level 1.
- R9: A control write with bit 2 set empties the transmit queue, and one with bit 1 set empties the receive queue. The level reads 0 on the next cycle, and a push in the same cycle is discarded. The other queue is untouched, and the rest of the byte is stored by the same write.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte readback |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_din | input | DW | Transmit push data |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_dout | output | DW | Transmit pop data, valid the cycle after a pop |
| tx_level | output | $clog2(DEPTH+1) | Transmit queue fill count |
| tx_req | output | 1 | Transmit refill request |
| tx_ovr | output | 1 | Transmit push dropped, one-cycle pulse |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_din | input | DW | Receive push data |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_dout | output | DW | Receive pop data, valid the cycle after a pop |
| rx_level | output | $clog2(DEPTH+1) | Receive queue fill count |
| rx_req | output | 1 | Receive drain request |
| rx_ovr | output | 1 | Receive push dropped, one-cycle pulse |

## Verification
The bench builds the block with `DEPTH`=64 and `DW`=8, the sizes the thresholds are specified for. At these values every limit can be reached: 16, 32 and 48 on the transmit side and 1, 8, 16 and 32 on the receive side. The bench checks each limit on both sides of the boundary. Filling 64 bytes also reaches the full condition, so the overrun pulse and the pointer wrap on the drain that follows are exercised.

// File: rtl/uft_pkg.sv
package uft_pkg;

  // Transmit request limit: at or below this count the host is asked to refill
  function automatic int tx_limit(input logic [1:0] code, input int depth);
    return int'(code) * (depth / 4);
  endfunction

  // Receive request limit: at or above this count the host is asked to drain
  function automatic int rx_limit(input logic [1:0] code, input int depth);
    if (code == 2'd0) return 1;
    return (depth / 8) << (int'(code) - 1);
  endfunction

endpackage

// File: rtl/uft_ctrl.sv
module uft_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       en,
  output logic [1:0] tx_code,
  output logic [1:0] rx_code,
  output logic       en_nxt,
  output logic [1:0] tx_code_nxt,
  output logic [1:0] rx_code_nxt,
  output logic       tx_flush,
  output logic       rx_flush
);
  logic rsvd_unused;
  assign rsvd_unused = wdata[3];

  always_comb begin
    en_nxt      = en;
    tx_code_nxt = tx_code;
    rx_code_nxt = rx_code;
    if (rst) begin
      en_nxt      = 1'b0;
      tx_code_nxt = 2'd0;
      rx_code_nxt = 2'd0;
    end else if (we) begin
      en_nxt      = wdata[0];
      tx_code_nxt = wdata[7:6];
      rx_code_nxt = wdata[5:4];
    end
  end

  always_ff @(posedge clk) begin
    en      <= en_nxt;
    tx_code <= tx_code_nxt;
    rx_code <= rx_code_nxt;
  end

  // Flush pulses act in the write cycle; they are never stored
  assign tx_flush = we & wdata[2] & ~rst;
  assign rx_flush = we & wdata[1] & ~rst;
  assign rdata    = {tx_code, rx_code, 3'b000, en};
endmodule

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          enable,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          ovr
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          full, do_push, do_pop;

  assign cap     = enable ? CW'(DEPTH) : CW'(1);
  assign full    = count >= cap;
  assign do_push = push & ~full & ~flush & ~rst;
  assign do_pop  = pop & (count != '0) & ~flush & ~rst;

  always_comb begin
    if (rst || flush) count_nxt = '0;
    else              count_nxt = count + CW'(do_push) - CW'(do_pop);
  end

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + AW'(1);
  endfunction

  // Storage without reset so a block RAM can hold it
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (do_pop) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
    end
    count <= count_nxt;
    ovr   <= push & full & ~flush & ~rst;
  end
endmodule

// File: rtl/uft_trigger.sv
module uft_trigger #(
  parameter bit IS_TX = 1'b1,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic [CW-1:0] count_nxt,
  input  logic          en_nxt,
  input  logic [1:0]    code_nxt,
  output logic          req
);
  import uft_pkg::*;
  logic hit;

  generate
    if (IS_TX) begin : g_tx
      always_comb begin
        if (!en_nxt || code_nxt == 2'd0) hit = (count_nxt == '0);
        else hit = int'(count_nxt) <= tx_limit(code_nxt, DEPTH);
      end
    end else begin : g_rx
      always_comb begin
        if (!en_nxt) hit = (count_nxt != '0);
        else         hit = int'(count_nxt) >= rx_limit(code_nxt, DEPTH);
      end
    end
  endgenerate

  // Next-state inputs already read zero under reset, so the flop resets with them
  always_ff @(posedge clk) req <= hit;
endmodule

// File: rtl/uart_fifo_trigctl.sv
module uart_fifo_trigctl #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_din,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_dout,
  output logic [CW-1:0] tx_level,
  output logic          tx_req,
  output logic          tx_ovr,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_din,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_dout,
  output logic [CW-1:0] rx_level,
  output logic          rx_req,
  output logic          rx_ovr
);
  logic       en, en_nxt, tx_flush, rx_flush;
  logic [1:0] tx_code, rx_code, tx_code_nxt, rx_code_nxt;
  logic [CW-1:0] tx_cnt_nxt, rx_cnt_nxt;
  logic       codes_unused;
  assign codes_unused = ^{tx_code, rx_code};

  uft_ctrl u_ctrl (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .en(en), .tx_code(tx_code), .rx_code(rx_code),
    .en_nxt(en_nxt), .tx_code_nxt(tx_code_nxt), .rx_code_nxt(rx_code_nxt),
    .tx_flush(tx_flush), .rx_flush(rx_flush)
  );

  uft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .enable(en),
    .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .count(tx_level), .count_nxt(tx_cnt_nxt), .ovr(tx_ovr)
  );

  uft_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .enable(en),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .count(rx_level), .count_nxt(rx_cnt_nxt), .ovr(rx_ovr)
  );

  uft_trigger #(.IS_TX(1'b1), .DEPTH(DEPTH)) u_txtrig (
    .clk(clk), .count_nxt(tx_cnt_nxt), .en_nxt(en_nxt),
    .code_nxt(tx_code_nxt), .req(tx_req)
  );

  uft_trigger #(.IS_TX(1'b0), .DEPTH(DEPTH)) u_rxtrig (
    .clk(clk), .count_nxt(rx_cnt_nxt), .en_nxt(en_nxt),
    .code_nxt(rx_code_nxt), .req(rx_req)
  );
endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_rdata,
  input logic          tx_push,
  input logic [DW-1:0] tx_din,
  input logic          tx_pop,
  input logic [DW-1:0] tx_dout,
  input logic [CW-1:0] tx_level,
  input logic          tx_req,
  input logic          tx_ovr,
  input logic          rx_push,
  input logic [DW-1:0] rx_din,
  input logic          rx_pop,
  input logic [DW-1:0] rx_dout,
  input logic [CW-1:0] rx_level,
  input logic          rx_req,
  input logic          rx_ovr
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[3:1] == 3'b000); // R2
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    int'(tx_level) <= int'($past(tx_level)) + 1); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(tx_level) <= DEPTH && int'(rx_level) <= DEPTH); // R4
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ovr) |-> $past(tx_push) && $past(tx_level) != '0); // R4
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rx_pop && rx_level == '0 && !rx_push && !(cfg_we && cfg_wdata[1]))
    |-> ($stable(rx_dout) && rx_level == '0)); // R5
  AST_TX_REQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    tx_level == '0 |-> tx_req); // R6
  AST_RX_REQ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_level == '0 |-> !rx_req); // R7
  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we && cfg_wdata[2]) |-> tx_level == '0); // R9
endmodule

bind uart_fifo_trigctl uft_checker #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_uart_fifo_trigctl.sv
`timescale 1ns/1ps
module tb_uart_fifo_trigctl;
  localparam int DW = 8, DEPTH = 64, CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0; logic [7:0] cfg_wdata = 0; logic [7:0] cfg_rdata;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_din = 0, rx_din = 0, tx_dout, rx_dout;
  logic [CW-1:0] tx_level, rx_level;
  logic tx_req, tx_ovr, rx_req, rx_ovr;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_fifo_trigctl #(.DW(DW), .DEPTH(DEPTH)) dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v; cyc(); cfg_we = 0; cfg_wdata = 0;
  endtask
  task automatic push_tx(input logic [7:0] v);
    tx_push = 1; tx_din = v; cyc(); tx_push = 0;
  endtask
  task automatic push_rx(input logic [7:0] v);
    rx_push = 1; rx_din = v; cyc(); rx_push = 0;
  endtask
  task automatic pop_tx(); tx_pop = 1; cyc(); tx_pop = 0; endtask
  task automatic pop_rx(); rx_pop = 1; cyc(); rx_pop = 0; endtask
  task automatic flush_all(input logic [7:0] keep);
    wr_cfg(keep | 8'h06);
  endtask

  function automatic int exp_tx_lim(input int c);
    case (c) 0: return 0; 1: return 16; 2: return 32; default: return 48; endcase
  endfunction
  function automatic int exp_rx_lim(input int c);
    case (c) 0: return 1; 1: return 8; 2: return 16; default: return 32; endcase
  endfunction

  task automatic t_reset();
    check("R1 cfg_rdata", cfg_rdata, 0);
    check("R1 tx_level", tx_level, 0);
    check("R1 rx_level", rx_level, 0);
    check("R1 tx_req", tx_req, 1);
    check("R1 rx_req", rx_req, 0);
    check("R1 ovr", {tx_ovr, rx_ovr}, 0);
  endtask

  task automatic t_cfg();
    wr_cfg(8'hFF);
    check("R2 readback all-ones write", cfg_rdata, 8'hF1);
    wr_cfg(8'b1001_1000);
    check("R2 readback fields", cfg_rdata, 8'b1001_0000);
    wr_cfg(8'h00);
  endtask

  task automatic t_order();
    wr_cfg(8'h01);
    for (int i = 0; i < 5; i++) push_tx(8'hA0 + 8'(i));
    check("R3 level after 5 pushes", tx_level, 5);
    for (int i = 0; i < 5; i++) begin
      pop_tx();
      check("R3 pop order", tx_dout, 8'hA0 + i);
    end
    check("R3 level drained", tx_level, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i * 3));
    check("R4 full level", rx_level, DEPTH);
    check("R4 no ovr before full push", rx_ovr, 0);
    rx_push = 1; rx_din = 8'hEE; cyc(); rx_push = 0;
    check("R4 ovr pulse", rx_ovr, 1);
    check("R4 level held", rx_level, DEPTH);
    cyc();
    check("R4 ovr one cycle", rx_ovr, 0);
    for (int i = 0; i < DEPTH; i++) begin
      pop_rx();
      check("R4 drain order", rx_dout, (i * 3) & 8'hFF);
    end
  endtask

  task automatic t_pop_empty();
    int last;
    last = rx_dout;
    pop_rx();
    check("R5 level stays 0", rx_level, 0);
    check("R5 dout held", rx_dout, last);
  endtask

  task automatic t_tx_thresh();
    for (int c = 0; c < 4; c++) begin
      wr_cfg(8'(c << 6) | 8'h01);
      check("R6 level 0 req", tx_req, 1);
      for (int n = 1; n <= 50; n++) begin
        push_tx(8'(n));
        check($sformatf("R6 code%0d level%0d", c, n), tx_req, int'(n <= exp_tx_lim(c)));
      end
      flush_all(8'(c << 6) | 8'h01);
    end
  endtask

  task automatic t_rx_thresh();
    for (int c = 0; c < 4; c++) begin
      wr_cfg(8'(c << 4) | 8'h01);
      check("R7 level 0 req", rx_req, 0);
      for (int n = 1; n <= 34; n++) begin
        push_rx(8'(n));
        check($sformatf("R7 code%0d level%0d", c, n), rx_req, int'(n >= exp_rx_lim(c)));
      end
      flush_all(8'(c << 4) | 8'h01);
    end
  endtask

  task automatic t_disabled();
    wr_cfg(8'hF0);
    push_tx(8'h11);
    check("R8 tx level 1", tx_level, 1);
    check("R8 tx_req off", tx_req, 0);
    push_tx(8'h22);
    check("R8 tx second push ovr", tx_ovr, 1);
    check("R8 tx level still 1", tx_level, 1);
    push_rx(8'h33);
    check("R8 rx_req at 1", rx_req, 1);
    pop_tx();
    check("R8 tx holding byte", tx_dout, 8'h11);
    check("R8 tx_req at 0", tx_req, 1);
    pop_rx();
    check("R8 rx_req at 0", rx_req, 0);
  endtask

  task automatic t_flush();
    wr_cfg(8'h01);
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    for (int i = 0; i < 3; i++) push_rx(8'h40 + 8'(i));
    tx_push = 1; tx_din = 8'h99;
    wr_cfg(8'h45);
    tx_push = 0;
    check("R9 tx emptied", tx_level, 0);
    check("R9 rx untouched", rx_level, 3);
    check("R9 fields stored, bit2 reads 0", cfg_rdata, 8'h41);
    wr_cfg(8'h03);
    check("R9 rx emptied", rx_level, 0);
    push_rx(8'h5A);
    pop_rx();
    check("R9 rx restarts at head", rx_dout, 8'h5A);
  endtask

  task automatic t_simul();
    wr_cfg(8'h01);
    for (int i = 0; i < 3; i++) push_tx(8'h70 + 8'(i));
    tx_push = 1; tx_din = 8'h7F; tx_pop = 1; cyc(); tx_push = 0; tx_pop = 0;
    check("R10 level unchanged", tx_level, 3);
    check("R10 head popped", tx_dout, 8'h70);
    flush_all(8'h01);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    t_reset();
    t_cfg();
    t_order();
    t_full();
    t_pop_empty();
    t_tx_thresh();
    t_rx_thresh();
    t_disabled();
    t_flush();
    t_simul();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule